// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a two-part logical address, a 4-bit segment number plus a 16-bit offset, into a physical address. It also checks whether the access is allowed. The segment descriptors sit in a table in memory. The block reads them through a simple read port: it holds the request until data comes back. A table-origin register gives where the table starts, and a table-size register gives how many segments it holds. The CPU side presents one request at a time, with an access kind of read, write or execute. It receives a single response pulse that carries either the physical address or a fault code.

Each descriptor is two 32-bit words, at table origin + 8 × segment. Word 0 holds the segment's physical start. Word 1 packs the segment length, a presence flag and three rights bits. The block keeps the last fetched descriptor together with its segment number. A request to the same segment then needs no memory traffic. Writing either table register drops that kept copy.

Top module: `seg_xlate`

## Requirements
- R1: A segment number equal to or above the table-size register gives fault code 1 (segment range). No memory read is made, and the response comes in the cycle after acceptance.
- R2: On a miss the block reads word 0 at origin + 8 × segment, then word 1 at that address + 4. Each read address is held until `mem_rd_valid_i` is high, and the data is taken in that same cycle.
- R3: Word 1 carries the length in bits 31..4, the presence flag in bit 3, and the read, write and execute rights in bits 2, 1 and 0.
- R4: A descriptor whose presence flag is 0 gives fault code 2 (absent segment).
- R5: Access kinds are encoded 0 = read, 1 = write, 2 = execute. A kind whose rights bit is 0 gives fault code 3 (rights). Kind 3 always gives fault code 3.
- R6: An offset equal to or above the length gives fault code 4 (bounds). Otherwise the fault code is 0 and the physical address is word 0 + offset, modulo 2^32.
- R7: Faults are ranked segment range, then absent, then rights, then bounds, and only the first one that applies is reported. On any fault the physical address reads 0.
- R8: A request for the segment held in the descriptor cache makes no memory read and responds in the cycle after acceptance. A segment-range fault leaves the cache unchanged.
- R9: A write to the table-origin or table-size register empties the descriptor cache. The next request for any segment fetches its descriptor again.
- R10: After reset `req_ready_o` is high, `rsp_valid_o` and `mem_rd_req_o` are low, the cache is empty, and the table size is 0, so every segment faults with code 1.
- R11: `req_ready_o` is low from acceptance until the response cycle. Each accepted request yields exactly one one-cycle `rsp_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_we_i | input | 1 | Write strobe for the table-origin register |
| cfg_base_i | input | 32 | New table origin |
| cfg_len_we_i | input | 1 | Write strobe for the table-size register |
| cfg_len_i | input | 5 | New table size, in segments |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Block can accept a request |
| req_seg_i | input | 4 | Segment number |
| req_off_i | input | 16 | Offset within the segment |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| mem_rd_req_o | output | 1 | Descriptor read request, held until valid |
| mem_rd_addr_o | output | 32 | Descriptor word address |
| mem_rd_valid_i | input | 1 | Read data valid |
| mem_rd_data_i | input | 32 | Read data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_paddr_o | output | 32 | Physical address, 0 on fault |
| rsp_fault_o | output | 3 | Fault code: 0 none, 1 range, 2 absent, 3 rights, 4 bounds |

## Verification
A cache hit or a segment-range fault responds in the cycle right after the accepting edge. A miss with a memory that answers each word L cycles after its request is seen responds 2L + 3 cycles after that edge. The bench works out this due cycle from its own memory latency setting, and on every falling edge it compares `rsp_valid_o` against it. A pulse that comes early, comes late or is missing fails at once. Each read grant is checked against a queue of expected addresses, so a hit that fetches anyway is caught.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int WORD_W    = 32;
  localparam int LIM_LSB   = 4;
  localparam int VLD_BIT   = 3;
  localparam int RD_BIT    = 2;
  localparam int WR_BIT    = 1;
  localparam int EX_BIT    = 0;
  localparam int DESC_SHIFT = 3;  // 8 bytes per descriptor
  localparam int W1_OFFSET = 4;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_ABSENT  = 3'd2,
    FLT_RIGHTS  = 3'd3,
    FLT_BOUNDS  = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef struct packed {
    logic [WORD_W-1:0] attr;
    logic [WORD_W-1:0] start;
  } desc_t;
endpackage

// File: rtl/seg_rights_check.sv
module seg_rights_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int AW    = 32
) (
  input  logic             range_bad_i,
  input  desc_t            desc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       acc_i,
  output fault_e           fault_o,
  output logic [AW-1:0]    paddr_o
);
  localparam int LIM_W = WORD_W - LIM_LSB;

  logic [LIM_W-1:0] lim;
  logic             allowed;

  assign lim = desc_i.attr[WORD_W-1:LIM_LSB];

  always_comb begin
    case (acc_e'(acc_i))
      ACC_RD:  allowed = desc_i.attr[RD_BIT];
      ACC_WR:  allowed = desc_i.attr[WR_BIT];
      ACC_EX:  allowed = desc_i.attr[EX_BIT];
      default: allowed = 1'b0;
    endcase
  end

  always_comb begin
    fault_o = FLT_NONE;
    paddr_o = '0;
    if (range_bad_i)                     fault_o = FLT_RANGE;
    else if (!desc_i.attr[VLD_BIT])      fault_o = FLT_ABSENT;
    else if (!allowed)                   fault_o = FLT_RIGHTS;
    else if (LIM_W'(off_i) >= lim)       fault_o = FLT_BOUNDS;
    else paddr_o = AW'(desc_i.start) + AW'(off_i);
  end
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inval_i,
  input  logic             fill_i,
  input  logic [SEG_W-1:0] fill_seg_i,
  input  desc_t            fill_desc_i,
  input  logic [SEG_W-1:0] lookup_seg_i,
  output logic             hit_o,
  output desc_t            desc_o
);
  logic             vld_q;
  logic [SEG_W-1:0] seg_q;
  desc_t            desc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      seg_q  <= '0;
      desc_q <= '0;
    end else if (inval_i) begin
      vld_q <= 1'b0;
    end else if (fill_i) begin
      vld_q  <= 1'b1;
      seg_q  <= fill_seg_i;
      desc_q <= fill_desc_i;
    end
  end

  assign hit_o  = vld_q && (seg_q == lookup_seg_i);
  assign desc_o = desc_q;

  p_inval_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !hit_o);
  p_fill_then_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !inval_i) ##1 (lookup_seg_i == $past(fill_seg_i)) |-> hit_o);
endmodule

// File: rtl/seg_table_walker.sv
module seg_table_walker
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int AW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [SEG_W-1:0] req_seg_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [1:0]       req_acc_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    tbl_base_i,
  input  logic [SEG_W:0]   tbl_len_i,
  input  logic             cfg_we_i,
  input  logic             hit_i,
  input  desc_t            cache_desc_i,
  output logic             mem_rd_req_o,
  output logic [AW-1:0]    mem_rd_addr_o,
  input  logic             mem_rd_valid_i,
  input  logic [WORD_W-1:0] mem_rd_data_i,
  output logic             fill_o,
  output logic [SEG_W-1:0] fill_seg_o,
  output desc_t            fill_desc_o,
  output logic             cur_bad_o,
  output desc_t            cur_desc_o,
  output logic [OFF_W-1:0] cur_off_o,
  output logic [1:0]       cur_acc_o,
  output logic             rsp_valid_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_W0, ST_W1, ST_RSP} state_e;

  state_e           state_q;
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       acc_q;
  logic             bad_q;
  logic             stale_q;
  logic [AW-1:0]    addr_q;
  desc_t            desc_q;

  logic             accept;
  logic             range_bad;
  logic [AW-1:0]    tab_addr;

  assign accept    = (state_q == ST_IDLE) && req_valid_i;
  assign range_bad = {1'b0, req_seg_i} >= tbl_len_i;
  assign tab_addr  = tbl_base_i + (AW'(req_seg_i) << DESC_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      seg_q   <= '0;
      off_q   <= '0;
      acc_q   <= '0;
      bad_q   <= 1'b0;
      stale_q <= 1'b0;
      addr_q  <= '0;
      desc_q  <= '0;
    end else begin
      // a config write during a walk must keep the result out of the cache
      if (accept)        stale_q <= cfg_we_i;
      else if (cfg_we_i) stale_q <= 1'b1;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          seg_q  <= req_seg_i;
          off_q  <= req_off_i;
          acc_q  <= req_acc_i;
          bad_q  <= range_bad;
          addr_q <= tab_addr;
          desc_q <= cache_desc_i;
          state_q <= (range_bad || hit_i) ? ST_RSP : ST_W0;
        end
        ST_W0: if (mem_rd_valid_i) begin
          desc_q.start <= mem_rd_data_i;
          state_q      <= ST_W1;
        end
        ST_W1: if (mem_rd_valid_i) begin
          desc_q.attr <= mem_rd_data_i;
          state_q     <= ST_RSP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign rsp_valid_o   = (state_q == ST_RSP);
  assign mem_rd_req_o  = (state_q == ST_W0) || (state_q == ST_W1);
  assign mem_rd_addr_o = (state_q == ST_W1) ? addr_q + AW'(W1_OFFSET) : addr_q;

  assign fill_o      = (state_q == ST_W1) && mem_rd_valid_i && !stale_q && !cfg_we_i;
  assign fill_seg_o  = seg_q;
  assign fill_desc_o = '{attr: mem_rd_data_i, start: desc_q.start};

  assign cur_bad_o  = bad_q;
  assign cur_desc_o = desc_q;
  assign cur_off_o  = off_q;
  assign cur_acc_o  = acc_q;

  p_hold_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_req_o && !mem_rd_valid_i) |=> (mem_rd_req_o && $stable(mem_rd_addr_o)));
  p_second_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_W0 && mem_rd_valid_i) |=>
      (mem_rd_req_o && mem_rd_addr_o == $past(mem_rd_addr_o) + AW'(W1_OFFSET)));
  p_fast_path_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (range_bad || hit_i)) |=> (rsp_valid_o && !mem_rd_req_o));
  p_single_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));
  p_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int AW    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_base_we_i,
  input  logic [AW-1:0]     cfg_base_i,
  input  logic              cfg_len_we_i,
  input  logic [SEG_W:0]    cfg_len_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [1:0]        req_acc_i,
  output logic              mem_rd_req_o,
  output logic [AW-1:0]     mem_rd_addr_o,
  input  logic              mem_rd_valid_i,
  input  logic [WORD_W-1:0] mem_rd_data_i,
  output logic              rsp_valid_o,
  output logic [AW-1:0]     rsp_paddr_o,
  output logic [2:0]        rsp_fault_o
);
  logic [AW-1:0]    base_q;
  logic [SEG_W:0]   len_q;
  logic             cfg_we;

  logic             hit;
  desc_t            cache_desc;
  logic             fill;
  logic [SEG_W-1:0] fill_seg;
  desc_t            fill_desc;
  logic             cur_bad;
  desc_t            cur_desc;
  logic [OFF_W-1:0] cur_off;
  logic [1:0]       cur_acc;
  logic             walk_rsp;
  fault_e           fault;
  logic [AW-1:0]    paddr;

  assign cfg_we = cfg_base_we_i || cfg_len_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (cfg_base_we_i) base_q <= cfg_base_i;
      if (cfg_len_we_i)  len_q  <= cfg_len_i;
    end
  end

  seg_desc_cache #(.SEG_W(SEG_W)) u_cache (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .inval_i      (cfg_we),
    .fill_i       (fill),
    .fill_seg_i   (fill_seg),
    .fill_desc_i  (fill_desc),
    .lookup_seg_i (req_seg_i),
    .hit_o        (hit),
    .desc_o       (cache_desc)
  );

  seg_table_walker #(.SEG_W(SEG_W), .OFF_W(OFF_W), .AW(AW)) u_walker (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_seg_i      (req_seg_i),
    .req_off_i      (req_off_i),
    .req_acc_i      (req_acc_i),
    .req_ready_o    (req_ready_o),
    .tbl_base_i     (base_q),
    .tbl_len_i      (len_q),
    .cfg_we_i       (cfg_we),
    .hit_i          (hit),
    .cache_desc_i   (cache_desc),
    .mem_rd_req_o   (mem_rd_req_o),
    .mem_rd_addr_o  (mem_rd_addr_o),
    .mem_rd_valid_i (mem_rd_valid_i),
    .mem_rd_data_i  (mem_rd_data_i),
    .fill_o         (fill),
    .fill_seg_o     (fill_seg),
    .fill_desc_o    (fill_desc),
    .cur_bad_o      (cur_bad),
    .cur_desc_o     (cur_desc),
    .cur_off_o      (cur_off),
    .cur_acc_o      (cur_acc),
    .rsp_valid_o    (walk_rsp)
  );

  seg_rights_check #(.OFF_W(OFF_W), .AW(AW)) u_check (
    .range_bad_i (cur_bad),
    .desc_i      (cur_desc),
    .off_i       (cur_off),
    .acc_i       (cur_acc),
    .fault_o     (fault),
    .paddr_o     (paddr)
  );

  assign rsp_valid_o = walk_rsp;
  assign rsp_paddr_o = paddr;
  assign rsp_fault_o = fault;

  p_fault_zero_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 3'd0) |-> (rsp_paddr_o == '0));
  p_fault_code_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_fault_o <= 3'd4));
  p_no_read_when_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_rd_req_o);
endmodule

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_base_we = 1'b0, cfg_len_we = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [4:0]  cfg_len = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_fault;

  always #2 clk = ~clk;

  seg_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_base_we_i(cfg_base_we), .cfg_base_i(cfg_base),
    .cfg_len_we_i(cfg_len_we), .cfg_len_i(cfg_len),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_seg_i(req_seg), .req_off_i(req_off), .req_acc_i(req_acc),
    .mem_rd_req_o(mem_req), .mem_rd_addr_o(mem_addr),
    .mem_rd_valid_i(mem_valid), .mem_rd_data_i(mem_data),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural memory, addresses below 1 KiB
  logic [31:0] mem [0:255];
  int lat = 2, wcnt = 0;
  logic [31:0] exp_addr_q [$];

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_valid = 1'b0; wcnt = 0;
    end else if (mem_valid) begin
      mem_valid = 1'b0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        mem_valid = 1'b1;
        mem_data = mem[mem_addr[9:2]];
        n_run++;
        if (exp_addr_q.size() == 0) begin
          n_fail++;
          $display("FAIL R8: unexpected read addr=%h expected none", mem_addr);
        end else begin
          logic [31:0] e;
          e = exp_addr_q.pop_front();
          if (e != mem_addr) begin
            n_fail++;
            $display("FAIL R2: read addr=%h expected %h", mem_addr, e);
          end
        end
      end else wcnt++;
    end
  end

  // reference model state
  logic [31:0] m_base = '0;
  int          m_len = 0;
  bit          mc_vld = 0;
  int          mc_seg = 0;
  bit          pending = 0;
  int          exp_due = 0;
  logic [31:0] exp_p;
  logic [2:0]  exp_f;
  string       exp_tag;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pending && cyc == exp_due) begin
        n_run++;
        if (!rsp_valid || rsp_paddr !== exp_p || rsp_fault !== exp_f) begin
          n_fail++;
          $display("FAIL %s: valid=%b paddr=%h fault=%0d expected valid=1 paddr=%h fault=%0d",
                   exp_tag, rsp_valid, rsp_paddr, rsp_fault, exp_p, exp_f);
        end
        pending = 0;
      end else if (rsp_valid) begin
        n_run++; n_fail++;
        $display("FAIL R11: rsp_valid=1 at cycle %0d expected 0", cyc);
      end
    end
  end

  function automatic logic [31:0] attr(input logic [27:0] lim, input bit v,
                                       input bit r, input bit w, input bit x);
    return {lim, v, r, w, x};
  endfunction

  task automatic put_desc(input logic [31:0] tb, input int seg,
                          input logic [31:0] start, input logic [31:0] a);
    mem[(tb + seg * 8) >> 2]       = start;
    mem[((tb + seg * 8) >> 2) + 1] = a;
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk); cfg_base_we = 1'b1; cfg_base = b;
    @(negedge clk); cfg_base_we = 1'b0;
    m_base = b; mc_vld = 0;
  endtask

  task automatic set_len(input int l);
    @(negedge clk); cfg_len_we = 1'b1; cfg_len = 5'(l);
    @(negedge clk); cfg_len_we = 1'b0;
    m_len = l; mc_vld = 0;
  endtask

  task automatic issue(input int seg, input logic [15:0] off, input logic [1:0] acc,
                       input string tag);
    logic [31:0] w0, w1;
    bit bad, hit, ok;
    int idx, due;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    idx = int'((m_base + seg * 8) >> 2);
    w0 = mem[idx]; w1 = mem[idx + 1];
    bad = (seg >= m_len);
    hit = mc_vld && (mc_seg == seg);
    case (acc)
      2'd0: ok = w1[2];
      2'd1: ok = w1[1];
      2'd2: ok = w1[0];
      default: ok = 0;
    endcase
    exp_p = 32'h0;
    if (bad)                              exp_f = 3'd1;
    else if (!w1[3])                      exp_f = 3'd2;
    else if (!ok)                         exp_f = 3'd3;
    else if ({12'h0, off} >= w1[31:4])    exp_f = 3'd4;
    else begin exp_f = 3'd0; exp_p = w0 + {16'h0, off}; end
    if (!bad && !hit) begin
      exp_addr_q.push_back(m_base + seg * 8);
      exp_addr_q.push_back(m_base + seg * 8 + 4);
      mc_vld = 1; mc_seg = seg;
      due = 2 * lat + 3;
    end else due = 0;
    req_valid = 1'b1; req_seg = 4'(seg); req_off = off; req_acc = acc;
    exp_due = cyc + 1 + due;
    exp_tag = tag;
    pending = 1;
    @(negedge clk);
    req_valid = 1'b0;
    if (due != 0) begin
      n_run++;
      if (req_ready !== 1'b0) begin
        n_fail++;
        $display("FAIL R11: req_ready=%b during walk expected 0", req_ready);
      end
    end
    while (pending) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    // table at 0x100
    put_desc(32'h100, 0, 32'h1000_0000, attr(28'h100, 1, 1, 1, 1));
    put_desc(32'h100, 1, 32'h0000_2000, attr(28'h40, 1, 1, 0, 0));
    put_desc(32'h100, 2, 32'h0000_4000, attr(28'h0, 0, 1, 1, 1));
    put_desc(32'h100, 3, 32'h0000_8000, attr(28'h0, 1, 1, 1, 0));
    put_desc(32'h100, 4, 32'h0000_3000, attr(28'h20, 1, 0, 0, 1));
    put_desc(32'h100, 5, 32'hFFFF_0000, attr(28'hFFF_FFFF, 1, 1, 0, 0));
    put_desc(32'h100, 6, 32'h0000_5000, attr(28'h100, 1, 1, 1, 1));
    put_desc(32'h100, 7, 32'h0000_6000, attr(28'h100, 1, 1, 1, 1));
    // table at 0x200
    put_desc(32'h200, 4, 32'h0000_7000, attr(28'h20, 1, 0, 0, 1));
    put_desc(32'h200, 15, 32'h0000_9000, attr(28'h10, 1, 1, 1, 0));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || mem_req !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: ready=%b rsp=%b memreq=%b expected 1 0 0", req_ready, rsp_valid, mem_req);
    end
    issue(0, 16'h0, 2'd0, "R10");            // size 0 after reset

    set_base(32'h100);
    set_len(6);
    lat = 2;
    issue(0, 16'h10, 2'd0, "R2");            // miss, fetch
    issue(0, 16'hFF, 2'd1, "R8");            // hit, last byte
    issue(0, 16'h100, 2'd2, "R6");           // offset == length
    issue(1, 16'h3F, 2'd1, "R5");            // write not allowed
    issue(1, 16'h3F, 2'd0, "R3");            // read allowed
    issue(1, 16'h0, 2'd3, "R5");             // reserved kind
    issue(2, 16'h0, 2'd0, "R4");             // absent
    issue(2, 16'h5, 2'd1, "R7");             // absent beats bounds
    issue(3, 16'h0, 2'd1, "R6");             // zero length
    issue(3, 16'h0, 2'd2, "R7");             // rights beat bounds
    issue(7, 16'h0, 2'd0, "R1");             // beyond size
    issue(3, 16'h0, 2'd0, "R8");             // cache kept after range fault
    issue(6, 16'h0, 2'd0, "R1");             // equal to size
    issue(5, 16'hFFFF, 2'd0, "R3");          // wide length field, top address
    lat = 0;
    issue(4, 16'h1F, 2'd2, "R6");
    issue(4, 16'h20, 2'd2, "R6");
    set_base(32'h200);
    issue(4, 16'h1F, 2'd2, "R9");            // refetch from new table
    set_len(6);
    issue(4, 16'h0, 2'd2, "R9");             // size write drops cache
    set_len(16);
    issue(15, 16'hF, 2'd1, "R1");            // top segment now legal
    issue(15, 16'h10, 2'd1, "R6");

    repeat (4) @(negedge clk);
    n_run++;
    if (exp_addr_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d reads outstanding expected 0", exp_addr_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL R11: watchdog expired, actual hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule